// File: doc/BRIEF.md
# Interrupt Code Receive Tracker

This block sits behind the receiver of a serial link and watches the stream of 8-bit control codes that arrive, one per single-cycle valid strobe, with two flag bits. Codes tagged as distributed-interrupt traffic are sorted into interrupts and acknowledges. The block keeps one status bit per interrupt number and uses it to drop duplicate interrupts and acknowledges that match no open interrupt.

An accepted event can set a sticky log bit, give a one-cycle notification pulse and raise a processor interrupt. Each of these depends on a per-number notification mask and on two enables. For each interrupt number, a mask can ask the transmitter to send an acknowledge automatically. The status bit is closed when the transmitter reports that the acknowledge went out.

The block also remembers which interrupt numbers were started by software. An incoming acknowledge is reported only for those numbers. Every received code, of any kind, is mirrored to a raw output bus with a one-cycle strobe. All configuration arrives as plain register inputs.

Top module: `irq_code_rx_tracker`

## Requirements
- R1: A code is an interrupt-type code only when `rx_valid` is 1, `rx_flags` equals 2'b10 and `cfg_rx_en` is 1. For such a code, bit 5 of `rx_code` picks the kind (0 = interrupt, 1 = acknowledge), bits 4:0 give the interrupt number, and bits 7:6 are ignored.
- R2: An interrupt code whose status bit is already 1 is dropped: no status, log, notification or interrupt change.
- R3: An acknowledge code whose status bit is 0 is dropped: no status, log, notification or interrupt change.
- R4: An accepted interrupt code sets its status bit. If `cfg_notify_mask` has that number's bit set, the matching `int_log` bit is set and `notify_pulse` is 1 for exactly the one cycle after the code's clock edge.
- R5: `irq` pulses together with `notify_pulse` only when `cfg_glob_ie` and `cfg_dist_ie` were both 1 when the code was taken.
- R6: An accepted interrupt code whose `cfg_autoack_mask` bit is 1 sets that number's `autoack_req` bit. A `txack_done` pulse with number `txack_num` clears both that request bit and that status bit.
- R7: An accepted acknowledge code clears its status bit. It sets the `ack_log` bit and pulses `notify_pulse` (and `irq` under R5) only when the notification mask bit is 1 and the number is marked as software-originated.
- R8: A `sw_int_sent` pulse marks `sw_int_num` as software-originated. The mark is removed when an acknowledge for that number is accepted.
- R9: Every `rx_valid` strobe, whatever the flags and enables, copies `rx_code` to `raw_code` and pulses `raw_valid` for one cycle.
- R10: Log bits are sticky. They are cleared only by the matching bit of `clr_int_log` / `clr_ack_log`. A set and a clear of the same bit in one cycle leaves it set.
- R11: After reset, every status, mark, request and log bit and every pulse output is 0.
- R12: A code with other flag values, or with `cfg_rx_en` at 0, changes no status, log, request or pulse output except the raw mirror.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received control code |
| rx_flags | input | 2 | Flag bits of the received code |
| rx_code | input | 8 | Received code value |
| cfg_rx_en | input | 1 | Interrupt-code reception enable |
| cfg_glob_ie | input | 1 | Global processor interrupt enable |
| cfg_dist_ie | input | 1 | Distributed-interrupt processor interrupt enable |
| cfg_notify_mask | input | 32 | Per-number notification mask |
| cfg_autoack_mask | input | 32 | Per-number automatic acknowledge mask |
| sw_int_sent | input | 1 | Software sent an interrupt code (pulse) |
| sw_int_num | input | 5 | Number of the software-sent interrupt |
| txack_done | input | 1 | Transmitter sent an automatic acknowledge (pulse) |
| txack_num | input | 5 | Number of the sent acknowledge |
| clr_int_log | input | 32 | Write-one-to-clear for interrupt log bits |
| clr_ack_log | input | 32 | Write-one-to-clear for acknowledge log bits |
| status | output | 32 | Per-number interrupt status |
| int_log | output | 32 | Sticky interrupt-received log |
| ack_log | output | 32 | Sticky acknowledge-received log |
| autoack_req | output | 32 | Pending automatic acknowledge requests |
| notify_pulse | output | 1 | One-cycle notification |
| irq | output | 1 | One-cycle processor interrupt |
| raw_valid | output | 1 | One-cycle strobe for the mirrored code |
| raw_code | output | 8 | Mirrored received code |

## Verification
The bench sends a repeated interrupt and a repeated acknowledge. A design that skipped the status filter would notify twice or log a stray acknowledge. It sends acknowledges for numbers that did and did not come from software, and clears the log between the two. A design that never cleared the software mark would still report the second acknowledge. It also covers the near-miss flag values, the unused upper code bits, the lowest and highest interrupt numbers, and a log set that lands in the same cycle as its clear. A mistake in any of these shows up as a wrong status bit, a lost sticky bit or a misplaced pulse.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam logic [1:0] FLAGS_IRQ = 2'b10;
  localparam int unsigned KIND_BIT = 5;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_INT  = 2'd1,
    KIND_ACK  = 2'd2
  } code_kind_e;

  // Decide what a received code means for the distribution logic.
  function automatic code_kind_e classify(input logic vld, input logic [1:0] flags,
                                          input logic [7:0] code, input logic en);
    if (!vld || !en || flags != FLAGS_IRQ) return KIND_NONE;
    return code[KIND_BIT] ? KIND_ACK : KIND_INT;
  endfunction

  // One-hot mask for an interrupt number.
  function automatic logic [31:0] num_onehot(input logic [4:0] num);
    return 32'd1 << num;
  endfunction
endpackage

// File: rtl/irq_code_classifier.sv
module irq_code_classifier
  import irq_trk_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned CODE_W  = 8,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ)
) (
  input  logic              rx_valid,
  input  logic [1:0]        rx_flags,
  input  logic [CODE_W-1:0] rx_code,
  input  logic              rx_en,
  input  logic [NUM_IRQ-1:0] status,
  output logic [NUM_W-1:0]  num,
  output logic              int_accept,
  output logic              ack_accept
);
  code_kind_e kind;
  logic       cur;

  always_comb begin
    kind = classify(rx_valid, rx_flags, rx_code[7:0], rx_en);
    num  = rx_code[NUM_W-1:0];
    cur  = status[num];
    int_accept = (kind == KIND_INT) && !cur;
    ack_accept = (kind == KIND_ACK) && cur;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               int_accept,
  input  logic               ack_accept,
  input  logic [NUM_W-1:0]   num,
  input  logic [NUM_IRQ-1:0] autoack_mask,
  input  logic               sw_set,
  input  logic [NUM_W-1:0]   sw_num,
  input  logic               txack_done,
  input  logic [NUM_W-1:0]   txack_num,
  output logic [NUM_IRQ-1:0] status,
  output logic [NUM_IRQ-1:0] sw_origin,
  output logic [NUM_IRQ-1:0] autoack_req
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    logic hit, st_set, st_clr, rq_set, rq_clr, sw_s, sw_c;
    always_comb begin
      hit    = (num == NUM_W'(i));
      st_set = int_accept && hit;
      st_clr = (ack_accept && hit) || (txack_done && txack_num == NUM_W'(i));
      rq_set = st_set && autoack_mask[i];
      rq_clr = txack_done && txack_num == NUM_W'(i);
      sw_s   = sw_set && sw_num == NUM_W'(i);
      sw_c   = ack_accept && hit;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status[i]      <= 1'b0;
        autoack_req[i] <= 1'b0;
        sw_origin[i]   <= 1'b0;
      end else begin
        if (st_set)      status[i] <= 1'b1;
        else if (st_clr) status[i] <= 1'b0;
        if (rq_set)      autoack_req[i] <= 1'b1;
        else if (rq_clr) autoack_req[i] <= 1'b0;
        if (sw_s)        sw_origin[i] <= 1'b1;
        else if (sw_c)   sw_origin[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_event_log.sv
module irq_event_log #(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               int_accept,
  input  logic               ack_accept,
  input  logic [NUM_W-1:0]   num,
  input  logic [NUM_IRQ-1:0] notify_mask,
  input  logic [NUM_IRQ-1:0] sw_origin,
  input  logic               glob_ie,
  input  logic               dist_ie,
  input  logic [NUM_IRQ-1:0] clr_int_log,
  input  logic [NUM_IRQ-1:0] clr_ack_log,
  output logic               ev_notify,
  output logic [NUM_IRQ-1:0] int_log,
  output logic [NUM_IRQ-1:0] ack_log,
  output logic               notify_pulse,
  output logic               irq
);
  logic int_note, ack_note;

  always_comb begin
    int_note  = int_accept && notify_mask[num];
    ack_note  = ack_accept && notify_mask[num] && sw_origin[num];
    ev_notify = int_note || ack_note;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_log
    logic hit;
    assign hit = (num == NUM_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        int_log[i] <= 1'b0;
        ack_log[i] <= 1'b0;
      end else begin
        if (int_note && hit)    int_log[i] <= 1'b1;
        else if (clr_int_log[i]) int_log[i] <= 1'b0;
        if (ack_note && hit)    ack_log[i] <= 1'b1;
        else if (clr_ack_log[i]) ack_log[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify_pulse <= 1'b0;
      irq          <= 1'b0;
    end else begin
      notify_pulse <= ev_notify;
      irq          <= ev_notify && glob_ie && dist_ie;
    end
  end
endmodule

// File: rtl/irq_code_rx_tracker.sv
module irq_code_rx_tracker #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned CODE_W  = 8,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [1:0]         rx_flags,
  input  logic [CODE_W-1:0]  rx_code,
  input  logic               cfg_rx_en,
  input  logic               cfg_glob_ie,
  input  logic               cfg_dist_ie,
  input  logic [NUM_IRQ-1:0] cfg_notify_mask,
  input  logic [NUM_IRQ-1:0] cfg_autoack_mask,
  input  logic               sw_int_sent,
  input  logic [NUM_W-1:0]   sw_int_num,
  input  logic               txack_done,
  input  logic [NUM_W-1:0]   txack_num,
  input  logic [NUM_IRQ-1:0] clr_int_log,
  input  logic [NUM_IRQ-1:0] clr_ack_log,
  output logic [NUM_IRQ-1:0] status,
  output logic [NUM_IRQ-1:0] int_log,
  output logic [NUM_IRQ-1:0] ack_log,
  output logic [NUM_IRQ-1:0] autoack_req,
  output logic               notify_pulse,
  output logic               irq,
  output logic               raw_valid,
  output logic [CODE_W-1:0]  raw_code
);
  // Internal events, named for the checker.
  logic               ev_int_accept;
  logic               ev_ack_accept;
  logic               ev_notify;
  logic [NUM_W-1:0]   ev_num;
  logic [NUM_IRQ-1:0] sw_origin;

  irq_code_classifier #(.NUM_IRQ(NUM_IRQ), .CODE_W(CODE_W)) u_cls (
    .rx_valid  (rx_valid),
    .rx_flags  (rx_flags),
    .rx_code   (rx_code),
    .rx_en     (cfg_rx_en),
    .status    (status),
    .num       (ev_num),
    .int_accept(ev_int_accept),
    .ack_accept(ev_ack_accept)
  );

  irq_status_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_accept  (ev_int_accept),
    .ack_accept  (ev_ack_accept),
    .num         (ev_num),
    .autoack_mask(cfg_autoack_mask),
    .sw_set      (sw_int_sent),
    .sw_num      (sw_int_num),
    .txack_done  (txack_done),
    .txack_num   (txack_num),
    .status      (status),
    .sw_origin   (sw_origin),
    .autoack_req (autoack_req)
  );

  irq_event_log #(.NUM_IRQ(NUM_IRQ)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_accept  (ev_int_accept),
    .ack_accept  (ev_ack_accept),
    .num         (ev_num),
    .notify_mask (cfg_notify_mask),
    .sw_origin   (sw_origin),
    .glob_ie     (cfg_glob_ie),
    .dist_ie     (cfg_dist_ie),
    .clr_int_log (clr_int_log),
    .clr_ack_log (clr_ack_log),
    .ev_notify   (ev_notify),
    .int_log     (int_log),
    .ack_log     (ack_log),
    .notify_pulse(notify_pulse),
    .irq         (irq)
  );

  // Raw mirror of every received code.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_valid <= 1'b0;
      raw_code  <= '0;
    end else begin
      raw_valid <= rx_valid;
      if (rx_valid) raw_code <= rx_code;
    end
  end
endmodule

// File: rtl/irq_trk_chk.sv
module irq_trk_chk #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned CODE_W  = 8,
  localparam int unsigned NUM_W  = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_valid,
  input logic [1:0]         rx_flags,
  input logic [CODE_W-1:0]  rx_code,
  input logic               cfg_rx_en,
  input logic               cfg_glob_ie,
  input logic               cfg_dist_ie,
  input logic [NUM_IRQ-1:0] cfg_autoack_mask,
  input logic [NUM_IRQ-1:0] clr_int_log,
  input logic [NUM_IRQ-1:0] clr_ack_log,
  input logic [NUM_IRQ-1:0] status,
  input logic [NUM_IRQ-1:0] int_log,
  input logic [NUM_IRQ-1:0] ack_log,
  input logic [NUM_IRQ-1:0] autoack_req,
  input logic               notify_pulse,
  input logic               irq,
  input logic               raw_valid,
  input logic [CODE_W-1:0]  raw_code,
  input logic               ev_int_accept,
  input logic               ev_ack_accept,
  input logic [NUM_W-1:0]   ev_num
);
  logic is_dist;
  assign is_dist = rx_valid && rx_flags == 2'b10 && cfg_rx_en;

  AST_NOTIFY_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    notify_pulse |-> $past(rx_valid)); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> notify_pulse && $past(cfg_glob_ie) && $past(cfg_dist_ie)); // R5
  AST_RAW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> raw_valid && raw_code == $past(rx_code)); // R9
  AST_DUP_INT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dist && !rx_code[5] && status[rx_code[NUM_W-1:0]]) |=> !notify_pulse); // R2
  AST_STRAY_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dist && rx_code[5] && !status[rx_code[NUM_W-1:0]] && clr_ack_log == '0)
      |=> !notify_pulse && ack_log == $past(ack_log)); // R3
  AST_INT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_int_accept |=> status[$past(ev_num)]); // R4
  AST_ACK_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_accept |=> !status[$past(ev_num)]); // R7
  AST_AUTOACK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_int_accept && cfg_autoack_mask[ev_num]) |=> autoack_req[$past(ev_num)]); // R6
  AST_LOG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_log) & ~int_log & ~$past(clr_int_log)) == '0); // R10
endmodule

bind irq_code_rx_tracker irq_trk_chk #(.NUM_IRQ(NUM_IRQ), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_flags(rx_flags), .rx_code(rx_code),
  .cfg_rx_en(cfg_rx_en), .cfg_glob_ie(cfg_glob_ie), .cfg_dist_ie(cfg_dist_ie),
  .cfg_autoack_mask(cfg_autoack_mask), .clr_int_log(clr_int_log), .clr_ack_log(clr_ack_log),
  .status(status), .int_log(int_log), .ack_log(ack_log), .autoack_req(autoack_req),
  .notify_pulse(notify_pulse), .irq(irq), .raw_valid(raw_valid), .raw_code(raw_code),
  .ev_int_accept(ev_int_accept), .ev_ack_accept(ev_ack_accept), .ev_num(ev_num)
);

// File: tb/irq_code_rx_tracker_tb.sv
`timescale 1ns/1ps
module irq_code_rx_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [1:0]  rx_flags = '0;
  logic [7:0]  rx_code = '0;
  logic        cfg_rx_en = 1'b1, cfg_glob_ie = 1'b1, cfg_dist_ie = 1'b1;
  logic [31:0] cfg_notify_mask = '1, cfg_autoack_mask = '0;
  logic        sw_int_sent = 1'b0, txack_done = 1'b0;
  logic [4:0]  sw_int_num = '0, txack_num = '0;
  logic [31:0] clr_int_log = '0, clr_ack_log = '0;
  logic [31:0] status, int_log, ack_log, autoack_req;
  logic        notify_pulse, irq, raw_valid;
  logic [7:0]  raw_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_code_rx_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_flags(rx_flags), .rx_code(rx_code),
    .cfg_rx_en(cfg_rx_en), .cfg_glob_ie(cfg_glob_ie), .cfg_dist_ie(cfg_dist_ie),
    .cfg_notify_mask(cfg_notify_mask), .cfg_autoack_mask(cfg_autoack_mask),
    .sw_int_sent(sw_int_sent), .sw_int_num(sw_int_num),
    .txack_done(txack_done), .txack_num(txack_num),
    .clr_int_log(clr_int_log), .clr_ack_log(clr_ack_log),
    .status(status), .int_log(int_log), .ack_log(ack_log), .autoack_req(autoack_req),
    .notify_pulse(notify_pulse), .irq(irq), .raw_valid(raw_valid), .raw_code(raw_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one code for one clock; returns at the next falling edge.
  task automatic send(input logic [1:0] f, input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_flags = f; rx_code = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // {flags[1:0], code[7:0], expected status bit, expected notify}
  localparam logic [11:0] VEC [0:9] = '{
    {2'b10, 8'h03, 1'b1, 1'b1},  // R4 new interrupt 3
    {2'b10, 8'h03, 1'b1, 1'b0},  // R2 duplicate
    {2'b10, 8'h23, 1'b0, 1'b0},  // R7 ack 3, not software -> silent
    {2'b10, 8'h23, 1'b0, 1'b0},  // R3 stray ack
    {2'b00, 8'h05, 1'b0, 1'b0},  // R12 other flags
    {2'b11, 8'h05, 1'b0, 1'b0},  // R12
    {2'b01, 8'h05, 1'b0, 1'b0},  // R12
    {2'b10, 8'h1F, 1'b1, 1'b1},  // R1 highest number
    {2'b10, 8'h3F, 1'b0, 1'b0},  // R1 ack highest
    {2'b10, 8'hC0, 1'b1, 1'b1}   // R1 bits 7:6 ignored, number 0
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 status", status, 0);
    chk("R11 logs", int_log | ack_log | autoack_req, 0);
    chk("R11 pulses", {29'd0, notify_pulse, irq, raw_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      logic [11:0] v;
      v = VEC[i];
      send(v[11:10], v[9:2]);
      chk($sformatf("R1 vec%0d status", i), 32'(status[v[6:2]]), 32'(v[1]));
      chk($sformatf("R4 vec%0d notify", i), 32'(notify_pulse), 32'(v[0]));
      chk($sformatf("R9 vec%0d raw", i), {23'd0, raw_valid, raw_code}, {24'd1, v[9:2]});
    end
    chk("R10 int_log sticky after table", int_log, 32'h8000_0009);
    chk("R3 ack_log untouched", ack_log, 0);
    @(negedge clk);
    chk("R9 raw strobe one cycle", 32'(raw_valid), 0);
    chk("R4 notify one cycle", 32'(notify_pulse), 0);

    // R4 masked notification
    cfg_notify_mask = ~32'h80;
    send(2'b10, 8'h07);
    chk("R4 masked status", 32'(status[7]), 1);
    chk("R4 masked notify", 32'(notify_pulse), 0);
    chk("R4 masked log", 32'(int_log[7]), 0);
    cfg_notify_mask = '1;

    // R5 enables
    cfg_glob_ie = 1'b0;
    send(2'b10, 8'h08);
    chk("R5 glob off notify", 32'(notify_pulse), 1);
    chk("R5 glob off irq", 32'(irq), 0);
    cfg_glob_ie = 1'b1; cfg_dist_ie = 1'b0;
    send(2'b10, 8'h0A);
    chk("R5 dist off irq", 32'(irq), 0);
    cfg_dist_ie = 1'b1;
    send(2'b10, 8'h0B);
    chk("R5 both on irq", 32'(irq), 1);

    // R6 automatic acknowledge
    cfg_autoack_mask = 32'h200;
    send(2'b10, 8'h09);
    chk("R6 request set", autoack_req, 32'h200);
    @(negedge clk);
    txack_done = 1'b1; txack_num = 5'd9;
    @(negedge clk);
    txack_done = 1'b0;
    chk("R6 status cleared", 32'(status[9]), 0);
    chk("R6 request cleared", autoack_req, 0);

    // R7 / R8 software-originated acknowledge
    @(negedge clk);
    sw_int_sent = 1'b1; sw_int_num = 5'd12;
    @(negedge clk);
    sw_int_sent = 1'b0;
    send(2'b10, 8'h0C);
    send(2'b10, 8'h2C);
    chk("R7 ack status", 32'(status[12]), 0);
    chk("R7 ack log", ack_log, 32'h1000);
    chk("R7 ack notify", 32'(notify_pulse), 1);
    chk("R5 ack irq", 32'(irq), 1);
    @(negedge clk);
    clr_ack_log = 32'h1000;
    @(negedge clk);
    clr_ack_log = '0;
    chk("R10 ack log w1c", ack_log, 0);
    send(2'b10, 8'h0C);
    send(2'b10, 8'h2C);
    chk("R8 mark removed notify", 32'(notify_pulse), 0);
    chk("R8 mark removed log", ack_log, 0);

    // R12 reception disabled
    cfg_rx_en = 1'b0;
    send(2'b10, 8'h19);
    chk("R12 disabled status", 32'(status[25]), 0);
    chk("R12 disabled notify", 32'(notify_pulse), 0);
    chk("R9 disabled raw", {23'd0, raw_valid, raw_code}, {24'd1, 8'h19});
    cfg_rx_en = 1'b1;

    // R10 set beats clear; clear touches only its bit
    @(negedge clk);
    rx_valid = 1'b1; rx_flags = 2'b10; rx_code = 8'h14; clr_int_log = 32'h0010_0000;
    @(negedge clk);
    rx_valid = 1'b0; clr_int_log = '0;
    chk("R10 set wins", 32'(int_log[20]), 1);
    clr_int_log = 32'h8;
    @(negedge clk);
    clr_int_log = '0;
    chk("R10 w1c one bit", int_log & 32'h8010_0008, 32'h8010_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule